// File: doc/BRIEF.md
# Channel Interrupt Request and Acknowledge Arbiter

This block gathers the interrupt sources of a sixteen-channel timer unit and turns them into one request on a shared priority bus. Each channel owns a status flag that the channel's time function sets with a one-cycle pulse. Each channel also owns a host-written enable bit. When at least one channel has both its flag and its enable set, the block drives exactly one of seven priority lines. A 3-bit level setting picks the line, and a level of zero silences the block.

When the processor acknowledges an interrupt, it signals the start of the acknowledge and presents the acknowledged priority. If that priority equals the block's level, the block has a request pending, and its arbitration number is non-zero, the block joins a serial contest on a wired-OR arbitration line. The contest sends the 4-bit arbitration number most significant bit first. A contender that sends a 0 while the line reads 1 drops out, so the highest number wins. The winner pulses a grant output and presents the lowest-numbered pending enabled channel as its vector offset.

The host clears status flags with a read-then-write handshake. A write of 0 clears a bit only if that bit read as 1 at the last status read. A set pulse from a time function beats a clear in the same cycle.

Top module: `chan_irq_ctrl`

## Requirements
- R1: A `flag_set` pulse on channel i makes `stat_q[i]` read 1 from the next cycle on. The bit then stays 1 until the host clears it.
- R2: When `en_wr` is high, `en_q` takes `en_wdata` on the next cycle. Otherwise `en_q` holds its value.
- R3: When `stat_wr` is high, `stat_q[i]` clears only if `stat_wdata[i]` is 0 and bit i read as 1 at the most recent `stat_rd` since the last `stat_wr`. A write of 1, or a write with no prior read of that bit, leaves the bit unchanged. A write used together with a read in the same cycle uses the capture from before that read.
- R4: A `flag_set` pulse on a bit that is being cleared in the same cycle leaves that bit at 1.
- R5: `irq_lines` bit k-1 is request line IRQk. It equals one-hot bit `cfg_level`-1 whenever `stat_q & en_q` is non-zero and `cfg_level` is non-zero, and it is all zero otherwise. It follows the registered state in the same cycle.
- R6: With `cfg_level` = 0, `irq_lines` is 0 whatever the flags and enables are.
- R7: An `iack_start` pulse starts a contest only if `iack_level` equals `cfg_level`, `cfg_level` is non-zero, `cfg_id` is non-zero, and a request is pending. Otherwise `arb_drive` stays 0 and no grant follows. An ID of 0 therefore never wins.
- R8: In the four cycles after a contest starts, `arb_drive` carries ID bits 3, 2, 1, 0 in turn while the block is still contending. The block leaves the contest at an edge where it drove 0 and `arb_bus_in` read 1.
- R9: The cycle after the fourth bit, `grant` is high for exactly one cycle if the block is still contending. `vec` then holds the lowest index set in `stat_q & en_q` as sampled on that edge, or 0 if none is set.
- R10: An `iack_start` pulse that arrives while a contest is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flag_set | input | 16 | Per-channel set pulses from the time functions |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 16 | Enable register write data |
| stat_rd | input | 1 | Host read of the status register (captures the bits seen as 1) |
| stat_wr | input | 1 | Host write of the status register |
| stat_wdata | input | 16 | Status write data; a 0 clears a previously read 1 |
| cfg_level | input | 3 | Request level, 0 disables |
| cfg_id | input | 4 | Arbitration number |
| iack_start | input | 1 | Acknowledge start pulse |
| iack_level | input | 3 | Acknowledged priority level |
| arb_bus_in | input | 1 | Resolved wired-OR arbitration line |
| stat_q | output | 16 | Status flags |
| en_q | output | 16 | Channel enables |
| irq_lines | output | 7 | Request lines, bit k-1 = IRQk |
| arb_drive | output | 1 | This block's bit onto the arbitration line |
| grant | output | 1 | One-cycle arbitration win |
| vec | output | 4 | Vector offset: lowest pending enabled channel |

## Verification
A bad flag or a lost read capture shows on `stat_q` on the next cycle. If the channel is enabled, it also shows on `irq_lines` in that same cycle. A wrong bit counter or contest state shows on `arb_drive` within one of the four bit cycles. At the latest, it shows as a missing or extra `grant` five cycles after `iack_start`. A wrong pick of the lowest pending channel appears only in `vec` during the grant cycle, so the bench compares `vec` on every grant.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  // Index of the lowest set bit, 0 when none is set.
  function automatic int unsigned lowest_set(input logic [15:0] v);
    int unsigned r;
    r = 0;
    for (int i = 15; i >= 0; i--)
      if (v[i]) r = i;
    return r;
  endfunction

  // One-hot line for a level: level L drives bit L-1, level 0 none.
  function automatic logic [6:0] level_to_line(input logic [2:0] lvl, input logic req);
    logic [6:0] r;
    r = '0;
    if (req && lvl != 3'd0) r[lvl - 3'd1] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/chan_irq_flags.sv
module chan_irq_flags #(
  parameter int N_CH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] flag_set,
  input  logic            en_wr,
  input  logic [N_CH-1:0] en_wdata,
  input  logic            stat_rd,
  input  logic            stat_wr,
  input  logic [N_CH-1:0] stat_wdata,
  output logic [N_CH-1:0] stat_q,
  output logic [N_CH-1:0] en_q,
  output logic [N_CH-1:0] pending
);
  logic [N_CH-1:0] armed_q;
  logic [N_CH-1:0] clr_req;

  assign clr_req = stat_wr ? (~stat_wdata & armed_q) : '0;
  assign pending = stat_q & en_q;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q[i]  <= 1'b0;
        en_q[i]    <= 1'b0;
        armed_q[i] <= 1'b0;
      end else begin
        if (flag_set[i])     stat_q[i] <= 1'b1;
        else if (clr_req[i]) stat_q[i] <= 1'b0;
        if (en_wr) en_q[i] <= en_wdata[i];
        if (stat_rd)      armed_q[i] <= stat_q[i];
        else if (stat_wr) armed_q[i] <= 1'b0;
      end
    end
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != '0) |=> ((stat_q & $past(flag_set)) == $past(flag_set))); // R4
  AST_NO_BLIND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr && flag_set == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R3
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_q)); // R2
endmodule

// File: rtl/chan_irq_level.sv
module chan_irq_level #(
  parameter int N_CH  = 16,
  parameter int LVL_W = 3,
  localparam int N_LINES = (1 << LVL_W) - 1
) (
  input  logic [N_CH-1:0]    pending,
  input  logic [LVL_W-1:0]   cfg_level,
  output logic [N_LINES-1:0] irq_lines
);
  logic any_req;
  assign any_req = |pending;

  for (genvar k = 0; k < N_LINES; k++) begin : g_line
    assign irq_lines[k] = any_req && (cfg_level == LVL_W'(k + 1));
  end

  always_comb begin
    AST_ONE_LINE: assert ($onehot0(irq_lines)); // R5
    AST_LEVEL_OFF: assert (cfg_level != '0 || irq_lines == '0); // R6
  end
endmodule

// File: rtl/chan_irq_arbiter.sv
module chan_irq_arbiter #(
  parameter int N_CH  = 16,
  parameter int LVL_W = 3,
  parameter int ID_W  = 4,
  localparam int VEC_W = $clog2(N_CH),
  localparam int IDX_W = $clog2(ID_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iack_start,
  input  logic [LVL_W-1:0] iack_level,
  input  logic [LVL_W-1:0] cfg_level,
  input  logic [ID_W-1:0]  cfg_id,
  input  logic [N_CH-1:0]  pending,
  input  logic             arb_bus_in,
  output logic             arb_drive,
  output logic             grant,
  output logic [VEC_W-1:0] vec
);
  import chan_irq_pkg::*;

  logic             busy_q;
  logic             in_q;
  logic [IDX_W-1:0] idx_q;
  logic [ID_W-1:0]  id_q;
  logic             may_contend;
  logic             lose_now;
  logic             last_bit;

  assign may_contend = iack_start && !busy_q && (iack_level == cfg_level) &&
                       (cfg_level != '0) && (cfg_id != '0) && (pending != '0);
  assign arb_drive   = busy_q && in_q && id_q[idx_q];
  assign lose_now    = busy_q && in_q && !arb_drive && arb_bus_in;
  assign last_bit    = busy_q && (idx_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      in_q   <= 1'b0;
      idx_q  <= '0;
      id_q   <= '0;
      grant  <= 1'b0;
      vec    <= '0;
    end else begin
      grant <= 1'b0;
      if (busy_q) begin
        if (lose_now) in_q <= 1'b0;
        if (last_bit) begin
          busy_q <= 1'b0;
          grant  <= in_q && !lose_now;
          vec    <= VEC_W'(lowest_set(16'(pending)));
        end else begin
          idx_q <= idx_q - 1'b1;
        end
      end else if (may_contend) begin
        busy_q <= 1'b1;
        in_q   <= 1'b1;
        idx_q  <= IDX_W'(ID_W - 1);
        id_q   <= cfg_id;
      end
    end
  end

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !arb_drive); // R7
  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant); // R9
  AST_ZERO_ID_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (id_q != '0)); // R7
  AST_OUT_STAYS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !in_q) |=> !arb_drive); // R8
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_bit) |=> (busy_q && $stable(id_q))); // R10
endmodule

// File: rtl/chan_irq_ctrl.sv
module chan_irq_ctrl #(
  parameter int N_CH  = 16,
  parameter int LVL_W = 3,
  parameter int ID_W  = 4,
  localparam int N_LINES = (1 << LVL_W) - 1,
  localparam int VEC_W   = $clog2(N_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CH-1:0]    flag_set,
  input  logic               en_wr,
  input  logic [N_CH-1:0]    en_wdata,
  input  logic               stat_rd,
  input  logic               stat_wr,
  input  logic [N_CH-1:0]    stat_wdata,
  input  logic [LVL_W-1:0]   cfg_level,
  input  logic [ID_W-1:0]    cfg_id,
  input  logic               iack_start,
  input  logic [LVL_W-1:0]   iack_level,
  input  logic               arb_bus_in,
  output logic [N_CH-1:0]    stat_q,
  output logic [N_CH-1:0]    en_q,
  output logic [N_LINES-1:0] irq_lines,
  output logic               arb_drive,
  output logic               grant,
  output logic [VEC_W-1:0]   vec
);
  logic [N_CH-1:0] pending;

  chan_irq_flags #(.N_CH(N_CH)) u_flags (
    .clk(clk), .rst_n(rst_n), .flag_set(flag_set),
    .en_wr(en_wr), .en_wdata(en_wdata),
    .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .stat_q(stat_q), .en_q(en_q), .pending(pending)
  );

  chan_irq_level #(.N_CH(N_CH), .LVL_W(LVL_W)) u_level (
    .pending(pending), .cfg_level(cfg_level), .irq_lines(irq_lines)
  );

  chan_irq_arbiter #(.N_CH(N_CH), .LVL_W(LVL_W), .ID_W(ID_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .iack_start(iack_start), .iack_level(iack_level),
    .cfg_level(cfg_level), .cfg_id(cfg_id), .pending(pending),
    .arb_bus_in(arb_bus_in), .arb_drive(arb_drive), .grant(grant), .vec(vec)
  );

  AST_REQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lines != '0) |-> ((stat_q & en_q) != '0)); // R5
endmodule

// File: tb/test_chan_irq_ctrl.sv
module test_chan_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] flag_set = '0, en_wdata = '0, stat_wdata = '0;
  logic en_wr = 0, stat_rd = 0, stat_wr = 0, iack_start = 0;
  logic [2:0] cfg_level = '0, iack_level = '0;
  logic [3:0] cfg_id = '0;
  logic [15:0] stat_q, en_q;
  logic [6:0] irq_lines;
  logic arb_drive, grant;
  logic [3:0] vec;
  logic arb_bus_in;

  // behavioural reference state
  logic [15:0] m_stat = '0, m_en = '0, m_armed = '0;
  int m_ph = 0;
  bit m_busy = 0, m_in = 0, m_grant = 0, o_in = 0;
  logic [3:0] m_id = '0, m_vec = '0, other_id = '0;
  bit other_present = 0;
  int checks = 0, errors = 0;
  int grants_seen = 0;

  always #4 clk = ~clk;

  function automatic bit idbit(input logic [3:0] id, input int ph);
    return id[3 - ph];
  endfunction

  function automatic logic [3:0] first_one(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return 4'(i);
    return 4'd0;
  endfunction

  function automatic logic [6:0] exp_lines(input logic [2:0] l, input logic [15:0] p);
    if (l == 0 || p == 0) return 7'd0;
    return 7'(1 << (int'(l) - 1));
  endfunction

  wire m_drive = m_busy && m_in && idbit(m_id, m_ph);
  wire o_drive = m_busy && o_in && idbit(other_id, m_ph);
  assign arb_bus_in = arb_drive | o_drive;

  chan_irq_ctrl i_chan_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .en_wr(en_wr), .en_wdata(en_wdata),
    .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .cfg_level(cfg_level), .cfg_id(cfg_id), .iack_start(iack_start),
    .iack_level(iack_level), .arb_bus_in(arb_bus_in), .stat_q(stat_q), .en_q(en_q),
    .irq_lines(irq_lines), .arb_drive(arb_drive), .grant(grant), .vec(vec)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model update
  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = '0; m_en = '0; m_armed = '0; m_busy = 0; m_in = 0;
      m_grant = 0; m_vec = '0; o_in = 0; m_ph = 0; m_id = '0;
    end else begin
      logic [15:0] pend, clr;
      bit bus, md, od, start_ok;
      pend = m_stat & m_en;
      md = m_drive; od = o_drive; bus = md | od;
      m_grant = 0;
      if (m_busy) begin
        if (m_in && !md && bus) m_in = 0;
        if (o_in && !od && bus) o_in = 0;
        if (m_ph == 3) begin
          m_busy = 0; m_grant = m_in; m_vec = first_one(pend);
        end else m_ph++;
      end else begin
        start_ok = iack_start && iack_level == cfg_level && cfg_level != 0 &&
                   cfg_id != 0 && pend != 0;
        if (start_ok) begin
          m_busy = 1; m_in = 1; m_ph = 0; m_id = cfg_id; o_in = other_present;
        end
      end
      clr = stat_wr ? (~stat_wdata & m_armed) : 16'h0;
      if (stat_rd) m_armed = m_stat; else if (stat_wr) m_armed = '0;
      m_stat = (m_stat & ~clr) | flag_set;
      if (en_wr) m_en = en_wdata;
    end
  end

  // compare on every clock, after outputs settle
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(stat_q == m_stat, "R1 R3 R4 status", 32'(stat_q), 32'(m_stat));
      chk(en_q == m_en, "R2 enable", 32'(en_q), 32'(m_en));
      chk(irq_lines == exp_lines(cfg_level, m_stat & m_en), "R5 R6 lines",
          32'(irq_lines), 32'(exp_lines(cfg_level, m_stat & m_en)));
      chk(arb_drive == m_drive, "R7 R8 drive", 32'(arb_drive), 32'(m_drive));
      chk(grant == m_grant, "R9 R10 grant", 32'(grant), 32'(m_grant));
      if (m_grant) begin
        grants_seen++;
        chk(vec == m_vec, "R9 vector", 32'(vec), 32'(m_vec));
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_set(input logic [15:0] v);
    flag_set = v; tick(); flag_set = '0;
  endtask

  task automatic write_en(input logic [15:0] v);
    en_wr = 1; en_wdata = v; tick(); en_wr = 0;
  endtask

  task automatic read_stat();
    stat_rd = 1; tick(); stat_rd = 0;
  endtask

  task automatic write_stat(input logic [15:0] v);
    stat_wr = 1; stat_wdata = v; tick(); stat_wr = 0;
  endtask

  task automatic ack(input logic [2:0] l, input bit other, input logic [3:0] oid);
    other_present = other; other_id = oid; iack_level = l; iack_start = 1;
    tick(); iack_start = 0;
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int g0;
    tick(3); rst_n = 1; tick();
    chk(stat_q == 0 && en_q == 0 && irq_lines == 0 && !grant, "R1 reset state",
        32'(stat_q), 32'h0);

    // R1 R2 R5: sets and enables, level sweep
    pulse_set(16'h0120);
    chk(stat_q == 16'h0120, "R1 set visible", 32'(stat_q), 32'h0120);
    write_en(16'h0100);
    for (int l = 0; l < 8; l++) begin
      cfg_level = 3'(l); tick();
      chk(irq_lines == exp_lines(3'(l), 16'h0100), "R5 level line",
          32'(irq_lines), 32'(exp_lines(3'(l), 16'h0100)));
    end
    cfg_level = 0; tick();
    chk(irq_lines == 0, "R6 level zero silent", 32'(irq_lines), 0);
    write_en(16'h0000); cfg_level = 3'd5; tick();
    chk(irq_lines == 0, "R5 no enabled flag", 32'(irq_lines), 0);

    // R3: clear handshake
    write_stat(16'h0000);
    chk(stat_q == 16'h0120, "R3 write without read", 32'(stat_q), 32'h0120);
    read_stat(); write_stat(16'hFFDF);
    chk(stat_q == 16'h0100, "R3 clear read bit", 32'(stat_q), 32'h0100);
    write_stat(16'h0000);
    chk(stat_q == 16'h0100, "R3 capture consumed", 32'(stat_q), 32'h0100);
    read_stat(); write_stat(16'hFFFF);
    chk(stat_q == 16'h0100, "R3 write one no effect", 32'(stat_q), 32'h0100);
    // R4: set wins over clear
    read_stat();
    stat_wr = 1; stat_wdata = 16'h0000; flag_set = 16'h0100; tick();
    stat_wr = 0; flag_set = '0;
    chk(stat_q == 16'h0100, "R4 set beats clear", 32'(stat_q), 32'h0100);
    // read and write together: old capture is empty, nothing clears
    stat_rd = 1; stat_wr = 1; stat_wdata = '0; tick(); stat_rd = 0; stat_wr = 0;
    chk(stat_q == 16'h0100, "R3 read+write same cycle", 32'(stat_q), 32'h0100);
    write_stat(16'h0000);
    chk(stat_q == 16'h0000, "R3 clear after combined read", 32'(stat_q), 32'h0);

    // arbitration
    pulse_set(16'h0A08); write_en(16'h0A00); cfg_level = 3'd4; cfg_id = 4'd9;
    g0 = grants_seen;
    ack(3'd3, 0, 0); tick(6);
    chk(grants_seen == g0, "R7 level mismatch no grant", grants_seen, g0);
    cfg_id = 0; ack(3'd4, 0, 0); tick(6);
    chk(grants_seen == g0, "R7 zero id never wins", grants_seen, g0);
    cfg_id = 4'd9; ack(3'd4, 0, 0); tick(6);
    chk(grants_seen == g0 + 1, "R9 lone contender wins", grants_seen, g0 + 1);
    chk(vec == 4'd9, "R9 lowest pending vector", 32'(vec), 9);
    ack(3'd4, 1, 4'd12); tick(6);
    chk(grants_seen == g0 + 1, "R8 higher id beats us", grants_seen, g0 + 1);
    ack(3'd4, 1, 4'd8); tick(6);
    chk(grants_seen == g0 + 2, "R8 lower id loses", grants_seen, g0 + 2);
    cfg_id = 4'd10; ack(3'd4, 1, 4'd11); tick(6);
    chk(grants_seen == g0 + 2, "R8 loses on last bit", grants_seen, g0 + 2);
    // R10: second start during a contest
    cfg_id = 4'd5; ack(3'd4, 0, 0); tick(1); ack(3'd4, 0, 0); tick(6);
    chk(grants_seen == g0 + 3, "R10 busy start ignored", grants_seen, g0 + 3);
    // pending changes during contest: vector follows the grant edge
    ack(3'd4, 0, 0); write_en(16'h0808); tick(6);
    chk(vec == 4'd3, "R9 vector at grant edge", 32'(vec), 3);
    cfg_level = 0; ack(3'd0, 0, 0); tick(6);
    chk(grants_seen == g0 + 4, "R7 level zero no contest", grants_seen, g0 + 4);

    tick(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule